// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block lets an on-chip host make single read and write accesses to an external peripheral. The peripheral sits on a 16-bit bus that carries both the low half of the address and the data. The host offers a request with a direction, a 26-bit address and write data. The block takes the request when its ready output is high. When the access ends, the block pulses a done signal and, for a read, returns the data it captured.

On the external side, every access starts with one cycle in which the shared bus is left undriven. The block then drives the low address bits onto the shared bus for two cycles, with an address-hold strobe so the peripheral can latch them. A configuration bit stretches this address phase to three cycles. After it comes a two-cycle data phase. The bus-start strobe marks the first data cycle. Read strobe or write enable is active across both data cycles. The upper ten address bits have their own lines.

The block runs only when a 3-bit bus-type setting selects the multiplexed mode. With any other setting, a request is refused at once and the bus stays quiet. Because each access opens with an undriven cycle, one access can follow another with no gap between them.

Top module: `muxbus_master`

## Requirements
- R1: While reset is high and right after it: `ext_cs_n`, `ext_rd_n`, `ext_we_n`, `ext_bs_n` and `ext_rdwr` are 1; `ext_ah`, `ext_ad_oe` and `rsp_done` are 0; `req_ready` is 1.
- R2: Multiplexed operation needs `cfg_bus_type` == 3'b010. With any other value, an accepted request makes `rsp_err` pulse high for one cycle, in the cycle after acceptance. `rsp_done` stays 0, `ext_cs_n` stays 1 and the shared bus is not driven.
- R3: The cycle right after a request is accepted is a turnaround cycle. In it `ext_ad_oe` is 0 and `ext_cs_n` is 1.
- R4: After the turnaround, the address phase lasts 2 cycles when `cfg_addr_ext` was 0 at acceptance and 3 cycles when it was 1. A later change of `cfg_addr_ext` does not affect an access already accepted. In every address cycle: `ext_cs_n` is 0, `ext_ah` is 1, `ext_ad_oe` is 1 and `ext_ad_out` equals address bits [15:0].
- R5: While `ext_cs_n` is 0, `ext_addr_hi` equals address bits [25:16] of the current access.
- R6: `ext_rdwr` is 1 for a read and 0 for a write, changes only together with `ext_cs_n`, and is 1 while `ext_cs_n` is 1.
- R7: The address phase is followed by exactly two data cycles, T1 and T2. In both, `ext_cs_n` is 0 and `ext_ah` is 0. `ext_bs_n` is 0 in T1 only. A write drives `req_wdata` with `ext_ad_oe` = 1 and holds `ext_we_n` at 0. A read holds `ext_rd_n` at 0 and `ext_ad_oe` at 0.
- R8: A read samples `ext_ad_in` at the end of T2. In the cycle after T2, `rsp_done` is 1 for one cycle, and for a read `rsp_rdata` holds the sampled value.
- R9: `req_ready` is 1 in idle and in T2, but only in T2 when `cfg_bus_type` selects multiplexed mode. A request accepted in T2 makes the next cycle the turnaround of the new access, so no idle cycle is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus cycle per clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bus_type | input | 3 | Bus-type setting; 3'b010 selects multiplexed mode |
| cfg_addr_ext | input | 1 | 1 lengthens the address phase to 3 cycles |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 26 | Access address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request is taken on a clock edge where valid and ready are both high |
| rsp_done | output | 1 | One-cycle pulse when an access completes |
| rsp_err | output | 1 | One-cycle pulse when a request is refused |
| rsp_rdata | output | 16 | Data captured by the last read |
| ext_cs_n | output | 1 | Chip select, active low |
| ext_ah | output | 1 | Address-hold strobe, active high |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_we_n | output | 1 | Write enable, active low |
| ext_rdwr | output | 1 | Direction: 1 read, 0 write |
| ext_bs_n | output | 1 | Bus-start strobe, active low |
| ext_addr_hi | output | 10 | Upper address bits [25:16] |
| ext_ad_out | output | 16 | Value driven onto the shared bus |
| ext_ad_oe | output | 1 | Output enable for the shared bus |
| ext_ad_in | input | 16 | Value read from the shared bus |

## Verification
Assertions watch for rules that can be judged on every cycle. The bus-start strobe never lasts more than one cycle. Read strobe and write enable are never low at the same time. The address-hold strobe only appears inside chip select. The bus is released while the read strobe is active. The direction line stays steady across an asserted chip select. Each acceptance is followed by an undriven turnaround, and a refusal leaves chip select high. The exact sequence of phases cannot be checked that way: the number of address cycles for each setting, the address and data values on the shared bus, the captured read data, and the back-to-back chaining. The bench shows these by sweeping direction, address length, chaining and every bus-type code, and predicting each cycle's pin values from the request.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    localparam int MB_ADDR_W = 26;
    localparam int MB_DATA_W = 16;
    localparam int MB_HI_W   = MB_ADDR_W - MB_DATA_W;
    localparam int MB_TYPE_W = 3;
    localparam logic [MB_TYPE_W-1:0] MB_TYPE_MUX = 3'b010;
    localparam int MB_ADDR_CYC = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TURN  = 3'd1,
        ST_ADDR  = 3'd2,
        ST_DATA1 = 3'd3,
        ST_DATA2 = 3'd4
    } mb_state_e;

    typedef struct packed {
        logic                 write;
        logic [MB_ADDR_W-1:0] addr;
        logic [MB_DATA_W-1:0] wdata;
    } mb_req_t;

    typedef struct packed {
        logic                 cs_n;
        logic                 ah;
        logic                 rd_n;
        logic                 we_n;
        logic                 rdwr;
        logic                 bs_n;
        logic                 oe;
        logic [MB_DATA_W-1:0] ad;
    } mb_pins_t;

    function automatic logic mb_type_ok(input logic [MB_TYPE_W-1:0] t);
        return t == MB_TYPE_MUX;
    endfunction

endpackage

// File: rtl/muxbus_seq.sv
module muxbus_seq
    import muxbus_pkg::*;
#(
    parameter int ADDR_CYC = MB_ADDR_CYC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MB_TYPE_W-1:0] cfg_type,
    input  logic                 cfg_ext,
    input  logic                 req_valid,
    output mb_state_e            state,
    output logic                 ready,
    output logic                 load,
    output logic                 reject
);
    localparam int CNT_W = $clog2(ADDR_CYC + 2);

    mb_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             type_ok;
    logic             take;
    logic             reject_q;

    assign type_ok = mb_type_ok(cfg_type);
    assign ready   = (st_q == ST_IDLE) || ((st_q == ST_DATA2) && type_ok);
    assign take    = req_valid && ready;
    assign load    = take && type_ok;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (load) st_d = ST_TURN;
            ST_TURN:  st_d = ST_ADDR;
            ST_ADDR:  if (cnt_q == '0) st_d = ST_DATA1;
            ST_DATA1: st_d = ST_DATA2;
            ST_DATA2: st_d = load ? ST_TURN : ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            reject_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            reject_q <= take && !type_ok;
            if (load)
                cnt_q <= CNT_W'(ADDR_CYC - 1) + CNT_W'(cfg_ext);
            else if ((st_q == ST_ADDR) && (cnt_q != '0))
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign state  = st_q;
    assign reject = reject_q;

    // R9: a request taken in T2 goes straight into the next turnaround
    assert_chain_no_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DATA2 && load) |=> (st_q == ST_TURN));

endmodule

// File: rtl/muxbus_pins.sv
module muxbus_pins
    import muxbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  mb_state_e            state,
    input  mb_req_t              req,
    input  logic [MB_DATA_W-1:0] ad_in,
    output mb_pins_t             pins,
    output logic [MB_DATA_W-1:0] rdata,
    output logic                 done
);
    logic                 done_q;
    logic [MB_DATA_W-1:0] rdata_q;

    always_comb begin
        pins      = '0;
        pins.cs_n = 1'b1;
        pins.rd_n = 1'b1;
        pins.we_n = 1'b1;
        pins.rdwr = 1'b1;
        pins.bs_n = 1'b1;
        unique case (state)
            ST_ADDR: begin
                pins.cs_n = 1'b0;
                pins.ah   = 1'b1;
                pins.rdwr = !req.write;
                pins.oe   = 1'b1;
                pins.ad   = req.addr[MB_DATA_W-1:0];
            end
            ST_DATA1, ST_DATA2: begin
                pins.cs_n = 1'b0;
                pins.rdwr = !req.write;
                pins.bs_n = (state != ST_DATA1);
                if (req.write) begin
                    pins.oe   = 1'b1;
                    pins.ad   = req.wdata;
                    pins.we_n = 1'b0;
                end else begin
                    pins.rd_n = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= (state == ST_DATA2);
            if ((state == ST_DATA2) && !req.write)
                rdata_q <= ad_in;
        end
    end

    assign done  = done_q;
    assign rdata = rdata_q;

    // R7: bus-start lasts a single cycle
    assert_bs_single_R7: assert property (@(posedge clk) disable iff (rst)
        !pins.bs_n |=> pins.bs_n);
    // R7: read strobe and write enable never overlap
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(!pins.rd_n && !pins.we_n));
    // R7: bus released while reading
    assert_rd_release_R7: assert property (@(posedge clk) disable iff (rst)
        !pins.rd_n |-> !pins.oe);
    // R4: address hold only inside chip select
    assert_ah_in_cs_R4: assert property (@(posedge clk) disable iff (rst)
        pins.ah |-> !pins.cs_n);
    // R6: direction steady across an asserted chip select
    assert_rdwr_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (!pins.cs_n && $past(!pins.cs_n)) |-> $stable(pins.rdwr));
    // R8: done is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

endmodule

// File: rtl/muxbus_master.sv
module muxbus_master
    import muxbus_pkg::*;
#(
    parameter int ADDR_CYC = MB_ADDR_CYC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MB_TYPE_W-1:0] cfg_bus_type,
    input  logic                 cfg_addr_ext,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [MB_ADDR_W-1:0] req_addr,
    input  logic [MB_DATA_W-1:0] req_wdata,
    output logic                 req_ready,
    output logic                 rsp_done,
    output logic                 rsp_err,
    output logic [MB_DATA_W-1:0] rsp_rdata,
    output logic                 ext_cs_n,
    output logic                 ext_ah,
    output logic                 ext_rd_n,
    output logic                 ext_we_n,
    output logic                 ext_rdwr,
    output logic                 ext_bs_n,
    output logic [MB_HI_W-1:0]   ext_addr_hi,
    output logic [MB_DATA_W-1:0] ext_ad_out,
    output logic                 ext_ad_oe,
    input  logic [MB_DATA_W-1:0] ext_ad_in
);
    mb_state_e state;
    logic      load;
    mb_req_t   req_q;
    mb_pins_t  pins;

    muxbus_seq #(.ADDR_CYC(ADDR_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cfg_type  (cfg_bus_type),
        .cfg_ext   (cfg_addr_ext),
        .req_valid (req_valid),
        .state     (state),
        .ready     (req_ready),
        .load      (load),
        .reject    (rsp_err)
    );

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= '0;
        else if (load)
            req_q <= '{write: req_write, addr: req_addr, wdata: req_wdata};
    end

    muxbus_pins u_pins (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .req   (req_q),
        .ad_in (ext_ad_in),
        .pins  (pins),
        .rdata (rsp_rdata),
        .done  (rsp_done)
    );

    assign ext_cs_n    = pins.cs_n;
    assign ext_ah      = pins.ah;
    assign ext_rd_n    = pins.rd_n;
    assign ext_we_n    = pins.we_n;
    assign ext_rdwr    = pins.rdwr;
    assign ext_bs_n    = pins.bs_n;
    assign ext_ad_oe   = pins.oe;
    assign ext_ad_out  = pins.ad;
    assign ext_addr_hi = req_q.addr[MB_ADDR_W-1:MB_DATA_W];

    // R3: the cycle after acceptance leaves the bus undriven and deselected
    assert_turn_hiz_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (ext_cs_n && !ext_ad_oe));
    // R2: a refusal produces no bus activity and no completion
    assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (ext_cs_n && !ext_ad_oe && !rsp_done));

endmodule

// File: tb/muxbus_master_bench.sv
module muxbus_master_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_bus_type = 3'b010;
    logic        cfg_addr_ext = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [25:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic        ext_cs_n, ext_ah, ext_rd_n, ext_we_n, ext_rdwr, ext_bs_n, ext_ad_oe;
    logic [9:0]  ext_addr_hi;
    logic [15:0] ext_ad_out, ext_ad_in, periph_lat;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  pend_done = 0;
    bit  pend_rd = 0;
    logic [15:0] pend_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    muxbus_master u_muxbus_master (
        .clk(clk), .rst(rst), .cfg_bus_type(cfg_bus_type), .cfg_addr_ext(cfg_addr_ext),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .ext_cs_n(ext_cs_n), .ext_ah(ext_ah),
        .ext_rd_n(ext_rd_n), .ext_we_n(ext_we_n), .ext_rdwr(ext_rdwr), .ext_bs_n(ext_bs_n),
        .ext_addr_hi(ext_addr_hi), .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe),
        .ext_ad_in(ext_ad_in)
    );

    // peripheral model: latches the address on the hold strobe, answers with a scrambled copy
    always @(posedge clk) if (ext_ah) periph_lat <= ext_ad_out;
    assign ext_ad_in = periph_lat ^ 16'hC35A;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic done_slot();
        chk("R8 done pulse", 32'(rsp_done), 32'(pend_done));
        if (pend_done && pend_rd) chk("R8 read data", 32'(rsp_rdata), 32'(pend_rdata));
        pend_done = 0;
    endtask

    task automatic present(input bit w, input logic [25:0] a, input logic [15:0] d, input bit e);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; cfg_addr_ext = e;
    endtask

    // request already presented at the current falling edge; returns at the T2 falling edge
    task automatic access(input bit w, input logic [25:0] a, input logic [15:0] d, input bit e);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_addr_ext = ~e;
        done_slot();
        chk("R3 turnaround cs_n", 32'(ext_cs_n), 32'd1);
        chk("R3 turnaround oe", 32'(ext_ad_oe), 32'd0);
        chk("R6 rdwr idle", 32'(ext_rdwr), 32'd1);
        chk("R9 ready low in turn", 32'(req_ready), 32'd0);
        for (int i = 0; i < 2 + int'(e); i++) begin
            @(negedge clk);
            chk("R4 addr cs_n", 32'(ext_cs_n), 32'd0);
            chk("R4 addr ah", 32'(ext_ah), 32'd1);
            chk("R4 addr oe", 32'(ext_ad_oe), 32'd1);
            chk("R4 addr value", 32'(ext_ad_out), 32'(a[15:0]));
            chk("R4 no bs in addr", 32'(ext_bs_n), 32'd1);
            chk("R5 upper addr", 32'(ext_addr_hi), 32'(a[25:16]));
            chk("R6 rdwr", 32'(ext_rdwr), 32'(!w));
        end
        for (int t = 1; t <= 2; t++) begin
            @(negedge clk);
            chk("R7 data cs_n", 32'(ext_cs_n), 32'd0);
            chk("R7 data ah", 32'(ext_ah), 32'd0);
            chk("R7 bs_n", 32'(ext_bs_n), (t == 1) ? 32'd0 : 32'd1);
            chk("R6 rdwr data", 32'(ext_rdwr), 32'(!w));
            chk("R5 upper addr data", 32'(ext_addr_hi), 32'(a[25:16]));
            chk("R7 oe", 32'(ext_ad_oe), 32'(w));
            chk("R7 we_n", 32'(ext_we_n), 32'(!w));
            chk("R7 rd_n", 32'(ext_rd_n), 32'(w));
            if (w) chk("R7 write data", 32'(ext_ad_out), 32'(d));
        end
        chk("R9 ready in T2", 32'(req_ready), 32'd1);
        pend_done = 1; pend_rd = !w; pend_rdata = a[15:0] ^ 16'hC35A;
    endtask

    task automatic idle_slot();
        @(negedge clk);
        done_slot();
        chk("R1 idle cs_n", 32'(ext_cs_n), 32'd1);
        chk("R9 ready idle", 32'(req_ready), 32'd1);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [25:0] mk_addr(input int k, input int s);
        return 26'(32'(k + 1) * 32'h0135_79B1 + 32'(s) * 32'h0002_4681);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", 32'(ext_cs_n), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cs_n", 32'(ext_cs_n), 32'd1);
        chk("R1 ah", 32'(ext_ah), 32'd0);
        chk("R1 rd_n", 32'(ext_rd_n), 32'd1);
        chk("R1 we_n", 32'(ext_we_n), 32'd1);
        chk("R1 bs_n", 32'(ext_bs_n), 32'd1);
        chk("R1 rdwr", 32'(ext_rdwr), 32'd1);
        chk("R1 oe", 32'(ext_ad_oe), 32'd0);
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 done", 32'(rsp_done), 32'd0);

        // every bus-type code other than the multiplexed one is refused
        for (int t = 0; t < 8; t++) begin
            if (t == 2) continue;
            cfg_bus_type = 3'(t);
            present(1'b1, mk_addr(t, 9), 16'hBEEF, 1'b0);
            @(negedge clk);
            req_valid = 1'b0;
            chk("R2 err pulse", 32'(rsp_err), 32'd1);
            chk("R2 no done", 32'(rsp_done), 32'd0);
            chk("R2 cs_n quiet", 32'(ext_cs_n), 32'd1);
            chk("R2 bus quiet", 32'(ext_ad_oe), 32'd0);
            @(negedge clk);
            chk("R2 err single", 32'(rsp_err), 32'd0);
            chk("R2 still quiet", 32'(ext_cs_n), 32'd1);
        end
        cfg_bus_type = 3'b010;

        // sweep: address length x direction, four accesses chained back to back
        for (int e = 0; e < 2; e++) begin
            for (int w = 0; w < 2; w++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [25:0] a;
                    logic [15:0] d;
                    a = mk_addr(k, e * 2 + w);
                    d = 16'(32'(k + 3) * 32'h1F3D) ^ 16'(e * 16'h0F0F);
                    present(1'(w), a, d, 1'(e));
                    access(1'(w), a, d, 1'(e));
                end
                idle_slot();
            end
        end

        // mixed directions chained, alternating address length
        for (int k = 0; k < 6; k++) begin
            present(1'(k % 2), mk_addr(k, 7), 16'(k * 4099), 1'((k / 2) % 2));
            access(1'(k % 2), mk_addr(k, 7), 16'(k * 4099), 1'((k / 2) % 2));
        end
        idle_slot();

        // T2 with a non-multiplexed setting: ready drops and no chaining happens
        present(1'b0, mk_addr(3, 3), 16'h0, 1'b1);
        access(1'b0, mk_addr(3, 3), 16'h0, 1'b1);
        cfg_bus_type = 3'b110;
        #1;
        chk("R9 ready gated by type in T2", 32'(req_ready), 32'd0);
        cfg_bus_type = 3'b010;
        idle_slot();
        idle_slot();

        finish_run();
    end
endmodule